// File: doc/BRIEF.md
# Wake-Pin Fast Restart Controller

This block brings a chip out of its low-power wait state when one of a set of wake pins is pulled to its active level. A mask register holds one enable bit per pin. Any enabled pin at its active level (low by default) raises a restart request through a purely combinational path, so the request exists even while every clock is stopped. That request turns the fast RC oscillator back on at once, with no clock edge needed.

Once the oscillator runs, the request is brought into the sequencer clock domain through a synchroniser chain. The sequencer then waits for the oscillator ready input. After ready it moves the master clock select onto the RC source, and one cycle later it ungates the processor clock. It holds that running state until the system asks to enter wait mode again. Nothing records which pin woke the chip; software reads the pin levels for that.

The sequence has a fixed, short cycle count after oscillator ready. This keeps the whole restart inside the startup budget of a few microseconds.

Top module: `wake_restart_ctrl`

## Requirements
- R1: The enable mask resets to all zeros; a cycle with `cfg_we_i` high loads `cfg_mask_i`, and bit i enables pin i.
- R2: `wake_req_o` is high exactly when some pin whose mask bit is 1 is at its active level (low for the default polarity); it is combinational and needs no clock edge.
- R3: A pin whose mask bit is 0 has no effect: `wake_req_o` stays low and the block stays in its sleeping outputs however long that pin sits low.
- R4: While sleeping, `osc_en_o` rises in the same instant as `wake_req_o`, before any clock edge, and it stays high through the rest of the restart.
- R5: `mclk_sel_rc_o` goes high only on the clock edge after one where `osc_ready_i` was sampled high in the oscillator-wait step. With ready already high, it goes high on edge SYNC_STAGES+2 counted from the request.
- R6: `cpu_clk_en_o` rises exactly one edge after `mclk_sel_rc_o` rises, and it is never high while `mclk_sel_rc_o` is low.
- R7: `wait_enter_i` high at an edge while running drives `osc_en_o`, `mclk_sel_rc_o` and `cpu_clk_en_o` all low after that edge.
- R8: After the restart completes, all three clock outputs stay high until `wait_enter_i`, even if the waking pin is released.
- R9: After reset the block is in its running state, with all three clock outputs high.
- R10: While `osc_ready_i` stays low, the sequencer holds `mclk_sel_rc_o` and `cpu_clk_en_o` low for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock (fast RC domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Mask register write strobe |
| cfg_mask_i | input | N_PINS | Mask write data, one enable per pin |
| wake_pin_i | input | N_PINS | Wake pins |
| wait_enter_i | input | 1 | Request to enter wait mode |
| osc_ready_i | input | 1 | Fast RC oscillator stable |
| wake_req_o | output | 1 | Asynchronous restart request |
| osc_en_o | output | 1 | Fast RC oscillator enable |
| mclk_sel_rc_o | output | 1 | Master clock select, 1 = RC source |
| cpu_clk_en_o | output | 1 | Processor clock enable |

## Verification
The bench goes after a masked-off pin held low for many cycles; a design that ignored the mask would wake the chip. It holds oscillator ready low after a wake; a design that switched the clock without ready would raise the select early and could produce a runt clock. It counts edges from the request to the select and the processor enable; a synchroniser with a stage missing, or a merged switch step, shows up as a transition one cycle early. It releases the waking pin after restart to catch a sequencer that falls back to sleep on its own. It also checks the oscillator enable before any clock edge, which catches a request path that was made synchronous.

// File: rtl/wake_pkg.sv
package wake_pkg;
   typedef enum logic [1:0] {
      ST_SLEEP  = 2'd0,
      ST_OSC    = 2'd1,
      ST_SWITCH = 2'd2,
      ST_ACTIVE = 2'd3
   } seq_state_t;
endpackage

// File: rtl/wake_mask_reg.sv
module wake_mask_reg #(
   parameter int          N_PINS   = 16,
   parameter logic [31:0] RST_MASK = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [N_PINS-1:0] wdata_i,
   output logic [N_PINS-1:0] mask_o
);
   localparam logic [N_PINS-1:0] RstVal = RST_MASK[N_PINS-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_o <= RstVal;
      else if (we_i) mask_o <= wdata_i;
   end

   // R1: the register takes the written value on the following edge
   p_mask_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
   parameter int N_PINS     = 16,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [N_PINS-1:0] pins_i,
   input  logic [N_PINS-1:0] mask_i,
   output logic              req_o
);
   logic [N_PINS-1:0] hit;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign hit = ~pins_i & mask_i;
      end else begin : g_high
         assign hit = pins_i & mask_i;
      end
   endgenerate

   assign req_o = |hit;
endmodule

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[0] <= 1'b0;
               else         chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[i] <= 1'b0;
               else         chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wake_seq.sv
module wake_seq
   import wake_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_sync_i,
   input  logic wait_enter_i,
   input  logic osc_ready_i,
   output logic osc_hold_o,
   output logic sel_rc_o,
   output logic cpu_en_o
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_SLEEP:  if (req_sync_i)   state_d = ST_OSC;
         ST_OSC:    if (osc_ready_i)  state_d = ST_SWITCH;
         ST_SWITCH:                   state_d = ST_ACTIVE;
         ST_ACTIVE: if (wait_enter_i) state_d = ST_SLEEP;
         default:                     state_d = ST_SLEEP;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_ACTIVE;
      else         state_q <= state_d;
   end

   assign osc_hold_o = (state_q != ST_SLEEP);
   assign sel_rc_o   = (state_q == ST_SWITCH) || (state_q == ST_ACTIVE);
   assign cpu_en_o   = (state_q == ST_ACTIVE);

   p_sel_needs_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sel_rc_o) |-> $past(osc_ready_i));
   p_cpu_after_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_en_o) |-> $past(sel_rc_o));
   p_cpu_needs_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_en_o |-> sel_rc_o);
   p_sleep_gates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_enter_i && cpu_en_o) |=> (!cpu_en_o && !sel_rc_o && !osc_hold_o));
   p_hold_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_en_o && !wait_enter_i) |=> cpu_en_o);
   p_no_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osc_hold_o && !sel_rc_o && !osc_ready_i) |=> !sel_rc_o);
endmodule

// File: rtl/wake_restart_ctrl.sv
module wake_restart_ctrl #(
   parameter int          N_PINS      = 16,
   parameter int          SYNC_STAGES = 2,
   parameter bit          ACTIVE_LOW  = 1'b1,
   parameter logic [31:0] RST_MASK    = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [N_PINS-1:0] cfg_mask_i,
   input  logic [N_PINS-1:0] wake_pin_i,
   input  logic              wait_enter_i,
   input  logic              osc_ready_i,
   output logic              wake_req_o,
   output logic              osc_en_o,
   output logic              mclk_sel_rc_o,
   output logic              cpu_clk_en_o
);
   initial begin : param_chk
      assert (N_PINS >= 1 && N_PINS <= 32) else $error("N_PINS must be 1..32");
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4) else $error("SYNC_STAGES must be 2..4");
   end

   logic [N_PINS-1:0] mask;
   logic              req_sync;
   logic              osc_hold;

   wake_mask_reg #(.N_PINS(N_PINS), .RST_MASK(RST_MASK)) u_mask (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
      .wdata_i(cfg_mask_i), .mask_o(mask));

   wake_detect #(.N_PINS(N_PINS), .ACTIVE_LOW(ACTIVE_LOW)) u_detect (
      .pins_i(wake_pin_i), .mask_i(mask), .req_o(wake_req_o));

   wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_req_o), .q_o(req_sync));

   wake_seq u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_sync_i(req_sync),
      .wait_enter_i(wait_enter_i), .osc_ready_i(osc_ready_i),
      .osc_hold_o(osc_hold), .sel_rc_o(mclk_sel_rc_o), .cpu_en_o(cpu_clk_en_o));

   // asynchronous oscillator start: no clock edge on this path
   assign osc_en_o = wake_req_o | osc_hold;

   p_sel_osc_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mclk_sel_rc_o |-> osc_en_o);
   p_req_starts_osc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_req_o |-> osc_en_o);
endmodule

// File: tb/wake_restart_ctrl_tb_top.sv
module wake_restart_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 16;
   localparam int SYNC       = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [N-1:0] cfg_mask = '0;
   logic [N-1:0] pins = '1;
   logic         wait_enter = 1'b0;
   logic         osc_ready = 1'b0;
   logic         wake_req, osc_en, sel_rc, cpu_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_restart_ctrl #(.N_PINS(N), .SYNC_STAGES(SYNC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mask_i(cfg_mask),
      .wake_pin_i(pins), .wait_enter_i(wait_enter), .osc_ready_i(osc_ready),
      .wake_req_o(wake_req), .osc_en_o(osc_en), .mclk_sel_rc_o(sel_rc),
      .cpu_clk_en_o(cpu_en));

   // {mask, pins, expected wake_req}
   typedef struct packed {
      logic [N-1:0] mask;
      logic [N-1:0] pins;
      logic         req;
   } vec_t;
   localparam vec_t VECS [7] = '{
      '{16'h0000, 16'h0000, 1'b0},
      '{16'h0001, 16'hFFFE, 1'b1},
      '{16'h0001, 16'hFFFD, 1'b0},
      '{16'h8000, 16'h7FFF, 1'b1},
      '{16'h00F0, 16'hFF0F, 1'b1},
      '{16'h00F0, 16'h0F0F | 16'hF0F0 & 16'hFF0F | 16'h00F0, 1'b0},
      '{16'hFFFF, 16'hFFFF, 1'b0}
   };

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {wake_req, osc_en, sel_rc, cpu_en};
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_mask(input logic [N-1:0] m);
      cfg_mask = m; cfg_we = 1'b1;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic enter_wait();
      wait_enter = 1'b1;
      step(1);
      wait_enter = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      step(2);
      // R9: reset state, clocks running
      check("R9", outs(), 4'b0111);
      rst_n = 1'b1;
      step(1);
      // R1: mask resets to zero, so all pins low give no request
      pins = '0; #1;
      check("R1", outs(), 4'b0111);
      pins = '1;

      // R2 / R3 vector table
      foreach (VECS[i]) begin
         write_mask(VECS[i].mask);
         pins = VECS[i].pins; #1;
         check(VECS[i].req ? "R2" : "R3", {3'b0, wake_req}, {3'b0, VECS[i].req});
         step(1);
      end
      pins = '1;

      // R7: entering wait gates everything
      write_mask(16'h8001);
      step(1);
      enter_wait();
      check("R7", outs(), 4'b0000);

      // R3: disabled pin 5 held low for many cycles
      pins[5] = 1'b0;
      step(8);
      check("R3", outs(), 4'b0000);
      pins[5] = 1'b1;

      // R4: enabled pin low, oscillator enable without any edge
      osc_ready = 1'b0;
      #1 pins[0] = 1'b0; #1;
      check("R4", outs(), 4'b1100);
      step(SYNC + 1);
      check("R4", outs(), 4'b1100);
      // R10: no ready, no switch
      step(6);
      check("R10", outs(), 4'b1100);
      osc_ready = 1'b1;
      step(1);
      check("R5", outs(), 4'b1110);
      step(1);
      check("R6", outs(), 4'b1111);
      // R8: release pin, hold running
      pins[0] = 1'b1;
      step(5);
      check("R8", outs(), 4'b0111);

      // second wake, ready already high: exact edge count (R5, R6)
      enter_wait();
      check("R7", outs(), 4'b0000);
      pins[15] = 1'b0;
      step(SYNC + 1);
      check("R5", outs(), 4'b1100);
      step(1);
      check("R5", outs(), 4'b1110);
      step(1);
      check("R6", outs(), 4'b1111);
      pins[15] = 1'b1;

      // R1: rewrite mask to drop pin 15, then pin 15 low is ignored in sleep
      write_mask(16'h0001);
      enter_wait();
      pins[15] = 1'b0;
      step(6);
      check("R1", outs(), 4'b0000);
      pins = '1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule